// File: doc/BRIEF.md
# Pipeline Interlock Stall Detector

This block decides, once per issued instruction, how many extra clock states the pipeline must wait before that instruction may proceed. Each instruction arrives with a set of resource-use flags. Some flags mark what it produces: a register auto-step, a special-register-space write, an implicit condition-flag update, an explicit flag-register write and an explicit stack-pointer write. Other flags mark what it consumes: an indirect internal-RAM read, a special-register-space read, a flag-register read, an implicit stack-pointer step and a conditional branch. The block keeps the producer flags of the last accepted instruction and checks them against the consumer flags of the instruction now being issued.

Branch-target alignment is judged from the current instruction alone. A taken standard jump to a misaligned 4-byte target costs extra states. A cached jump costs extra states only when the target and the instruction after it are both misaligned 4-byte instructions. When several rules match, the stall is the largest matching penalty. The stall appears as a down-counter together with a busy flag, and the pipeline is held while the flag is high.

Top module: `ilk_stall_unit`

## Requirements
- R1: After reset, stall_cnt is 0 and stall_busy is 0, and the stored producer flags are clear, so the first accepted instruction takes no interlock penalty.
- R2: An accepted instruction with ind_ram_rd=1, directly after an accepted instruction with reg_step=1, loads stall_cnt with 1.
- R3: An accepted instruction with sfr_rd=1, directly after an accepted instruction with sfr_wr=1, loads 1.
- R4: An accepted instruction with flag_rd=1, directly after an accepted instruction with flag_upd=1, loads 2.
- R5: An accepted instruction with sp_implicit=1, directly after an accepted instruction with sp_wr=1, loads 2.
- R6: An accepted instruction with cond_br=1, directly after an accepted instruction with flag_wr=1, loads 1.
- R7: An accepted instruction with jump_std=1, tgt_wide=1 and tgt_lo=2'b10 loads 2. An aligned target (tgt_lo=2'b00) or a 2-byte target adds nothing.
- R8: An accepted instruction with jump_cached=1 loads 2 only when tgt_wide=1, tgt_lo=2'b10, succ_wide=1 and succ_lo=2'b10 all hold. Otherwise it adds nothing.
- R9: A penalty needs the producer and the consumer to be adjacent. If any accepted instruction lies between them, no penalty applies, and a consumer flag with no matching producer adds nothing.
- R10: When several rules match, stall_cnt is loaded with the largest matching penalty, not the sum.
- R11: An instruction is accepted at a rising edge where issue_valid=1 and stall_busy=0. After a load of N, stall_busy stays high for exactly N clocks while stall_cnt steps down by 1 per clock. Any issue presented while stall_busy=1 is ignored: it neither reloads the count nor changes the stored producer flags.
- R12: Clocks with issue_valid=0 are not instructions. They do not separate a producer from its consumer, and their flags load nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented for issue |
| reg_step | input | 1 | Instruction auto-increments or auto-decrements a register |
| sfr_wr | input | 1 | Instruction writes the special-register space |
| flag_upd | input | 1 | Instruction implicitly updates the condition flags |
| flag_wr | input | 1 | Instruction explicitly writes the flag register |
| sp_wr | input | 1 | Instruction explicitly writes the stack pointer |
| ind_ram_rd | input | 1 | Instruction reads internal RAM indirectly |
| sfr_rd | input | 1 | Instruction reads the special-register space |
| flag_rd | input | 1 | Instruction reads the flag register |
| sp_implicit | input | 1 | Instruction implicitly steps the stack pointer |
| cond_br | input | 1 | Instruction is a conditional branch |
| jump_std | input | 1 | A standard jump is taken |
| jump_cached | input | 1 | A cached jump is taken |
| tgt_wide | input | 1 | The jump target is a 4-byte instruction |
| tgt_lo | input | 2 | Target address bits [1:0] |
| succ_wide | input | 1 | The instruction after the cached target is 4 bytes |
| succ_lo | input | 2 | Address bits [1:0] of that successor |
| stall_cnt | output | CNT_W | Extra states still to wait |
| stall_busy | output | 1 | Holds the pipeline while the count is nonzero |

## Verification
A corrupted stored producer flag shows up on the very next accepted instruction: stall_cnt then takes a wrong value one edge after acceptance, either a penalty that should not be there or one that is missing. A counter that decrements wrongly, or that reloads while busy, changes how long stall_busy stays high. The bench therefore times every stall window, and it presents conflicting instructions while the unit is busy, so that leaked updates appear on the instruction that follows.

// File: rtl/ilk_pkg.sv
// Shared types for the interlock stall unit.
// Assumes producer and consumer flags of one instruction arrive together.
package ilk_pkg;

    typedef struct packed {
        logic reg_step;
        logic sfr_wr;
        logic flag_upd;
        logic flag_wr;
        logic sp_wr;
    } prod_t;

    typedef struct packed {
        logic ind_ram_rd;
        logic sfr_rd;
        logic flag_rd;
        logic sp_implicit;
        logic cond_br;
    } cons_t;

    localparam int unsigned NRULE = 5;
    localparam logic [1:0] MISALIGNED_LO = 2'b10;

endpackage

// File: rtl/ilk_hazard_eval.sv
// Evaluates the one-instruction-back hazard rules and returns the largest
// matching penalty. Assumes prev holds the last accepted producer flags.
module ilk_hazard_eval
    import ilk_pkg::*;
#(
    parameter int unsigned CNT_W = 3,
    parameter logic [NRULE*CNT_W-1:0] PEN_VEC = '0
) (
    input  prod_t              prev,
    input  cons_t              cur,
    output logic [CNT_W-1:0]   pen
);

    logic [NRULE-1:0]             hit;
    logic [NRULE-1:0][CNT_W-1:0]  val;

    // Pair each producer with the consumer it blocks.
    always_comb begin
        hit[0] = prev.reg_step & cur.ind_ram_rd;
        hit[1] = prev.sfr_wr   & cur.sfr_rd;
        hit[2] = prev.flag_upd & cur.flag_rd;
        hit[3] = prev.sp_wr    & cur.sp_implicit;
        hit[4] = prev.flag_wr  & cur.cond_br;
    end

    // Mask each rule's penalty with its hit.
    for (genvar g = 0; g < NRULE; g++) begin : g_rule
        assign val[g] = hit[g] ? PEN_VEC[g*CNT_W +: CNT_W] : '0;
    end

    // Reduce by maximum over all rules.
    always_comb begin
        pen = '0;
        for (int i = 0; i < NRULE; i++) begin
            if (val[i] > pen) pen = val[i];
        end
    end

endmodule

// File: rtl/ilk_align_eval.sv
// Branch-target alignment penalty of the current instruction alone.
// Assumes at most one of jump_std and jump_cached is set.
module ilk_align_eval
    import ilk_pkg::*;
#(
    parameter int unsigned CNT_W = 3,
    parameter int unsigned PEN_ALIGN = 2
) (
    input  logic             jump_std,
    input  logic             jump_cached,
    input  logic             tgt_wide,
    input  logic [1:0]       tgt_lo,
    input  logic             succ_wide,
    input  logic [1:0]       succ_lo,
    output logic [CNT_W-1:0] pen
);

    logic tgt_mis, succ_mis;

    // Decide the penalty from the target and successor placement.
    always_comb begin
        tgt_mis  = tgt_wide  && (tgt_lo  == MISALIGNED_LO);
        succ_mis = succ_wide && (succ_lo == MISALIGNED_LO);
        if ((jump_std && tgt_mis) || (jump_cached && tgt_mis && succ_mis))
            pen = CNT_W'(PEN_ALIGN);
        else
            pen = '0;
    end

endmodule

// File: rtl/ilk_stall_ctr.sv
// Stall down-counter: loads on acceptance, then counts down to zero.
// Assumes load only arrives while the count is zero.
module ilk_stall_ctr #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             busy
);

    // Load the penalty or step the count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    // Busy while any state remains.
    assign busy = (cnt != '0);

endmodule

// File: rtl/ilk_stall_unit.sv
// Top of the interlock stall detector. Accepts an instruction when idle,
// computes its stall from the stored producer flags and its own alignment,
// and records its producer flags. Assumes the flags are stable at issue.
module ilk_stall_unit
    import ilk_pkg::*;
#(
    parameter int unsigned CNT_W       = 3,
    parameter int unsigned PEN_STEP    = 1,
    parameter int unsigned PEN_SFR     = 1,
    parameter int unsigned PEN_FLAG_RD = 2,
    parameter int unsigned PEN_SP      = 2,
    parameter int unsigned PEN_COND    = 1,
    parameter int unsigned PEN_ALIGN   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic             reg_step,
    input  logic             sfr_wr,
    input  logic             flag_upd,
    input  logic             flag_wr,
    input  logic             sp_wr,
    input  logic             ind_ram_rd,
    input  logic             sfr_rd,
    input  logic             flag_rd,
    input  logic             sp_implicit,
    input  logic             cond_br,
    input  logic             jump_std,
    input  logic             jump_cached,
    input  logic             tgt_wide,
    input  logic [1:0]       tgt_lo,
    input  logic             succ_wide,
    input  logic [1:0]       succ_lo,
    output logic [CNT_W-1:0] stall_cnt,
    output logic             stall_busy
);

    localparam logic [NRULE*CNT_W-1:0] PEN_VEC = {
        CNT_W'(PEN_COND), CNT_W'(PEN_SP), CNT_W'(PEN_FLAG_RD),
        CNT_W'(PEN_SFR),  CNT_W'(PEN_STEP)};

    prod_t            prev_q, cur_prod;
    cons_t            cur_cons;
    logic             accept;
    logic [CNT_W-1:0] pen_haz, pen_aln, pen_tot;

    // Gather the current flags into the shared types.
    always_comb begin
        cur_prod = '{reg_step: reg_step, sfr_wr: sfr_wr, flag_upd: flag_upd,
                     flag_wr: flag_wr, sp_wr: sp_wr};
        cur_cons = '{ind_ram_rd: ind_ram_rd, sfr_rd: sfr_rd, flag_rd: flag_rd,
                     sp_implicit: sp_implicit, cond_br: cond_br};
        accept   = issue_valid && !stall_busy;
    end

    ilk_hazard_eval #(.CNT_W(CNT_W), .PEN_VEC(PEN_VEC)) haz_i (
        .prev (prev_q),
        .cur  (cur_cons),
        .pen  (pen_haz)
    );

    ilk_align_eval #(.CNT_W(CNT_W), .PEN_ALIGN(PEN_ALIGN)) aln_i (
        .jump_std    (jump_std),
        .jump_cached (jump_cached),
        .tgt_wide    (tgt_wide),
        .tgt_lo      (tgt_lo),
        .succ_wide   (succ_wide),
        .succ_lo     (succ_lo),
        .pen         (pen_aln)
    );

    // Larger of the hazard and alignment penalties.
    assign pen_tot = (pen_haz > pen_aln) ? pen_haz : pen_aln;

    // Record producer flags only for accepted instructions.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= '0;
        else if (accept) prev_q <= cur_prod;
    end

    ilk_stall_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (pen_tot),
        .cnt      (stall_cnt),
        .busy     (stall_busy)
    );

endmodule

// File: rtl/ilk_stall_unit_chk.sv
// Port-level checker for the interlock stall unit, bound to the top.
module ilk_stall_unit_chk #(
    parameter int unsigned CNT_W     = 3,
    parameter int unsigned PEN_ALIGN = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic             ind_ram_rd,
    input logic             sfr_rd,
    input logic             flag_rd,
    input logic             sp_implicit,
    input logic             cond_br,
    input logic             jump_std,
    input logic             jump_cached,
    input logic             tgt_wide,
    input logic [1:0]       tgt_lo,
    input logic             succ_wide,
    input logic [1:0]       succ_lo,
    input logic [CNT_W-1:0] stall_cnt,
    input logic             stall_busy
);

    // Count is clear in the first cycle out of reset.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stall_cnt == '0));

    // While busy, the count only steps down, whatever is presented.
    assert_busy_steps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stall_busy |=> (stall_cnt == $past(stall_cnt) - 1'b1));

    // An accepted instruction with no consumer flag and no jump loads zero.
    assert_no_hazard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !stall_busy && !ind_ram_rd && !sfr_rd && !flag_rd &&
         !sp_implicit && !cond_br && !jump_std && !jump_cached)
        |=> (stall_cnt == '0));

    // A standard jump to a misaligned wide target loads the alignment penalty.
    assert_std_misalign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !stall_busy && jump_std && tgt_wide && tgt_lo == 2'b10)
        |=> (stall_cnt >= CNT_W'(PEN_ALIGN)));

    // A cached jump with target and successor misaligned loads the penalty.
    assert_cache_misalign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !stall_busy && jump_cached && tgt_wide && tgt_lo == 2'b10 &&
         succ_wide && succ_lo == 2'b10)
        |=> (stall_cnt >= CNT_W'(PEN_ALIGN)));

    // Without an issue the idle unit stays idle.
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_valid && !stall_busy) |=> (stall_cnt == '0));

endmodule

bind ilk_stall_unit ilk_stall_unit_chk #(.CNT_W(CNT_W), .PEN_ALIGN(PEN_ALIGN)) chk_i (.*);

// File: tb/ilk_stall_unit_tb_top.sv
module ilk_stall_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 3;
    localparam int NVEC = 14;

    // Stimulus word bits: 0 reg_step, 1 sfr_wr, 2 flag_upd, 3 flag_wr, 4 sp_wr,
    // 5 ind_ram_rd, 6 sfr_rd, 7 flag_rd, 8 sp_implicit, 9 cond_br,
    // 10 jump_std, 11 jump_cached, 12 tgt_wide, 13 succ_wide,
    // 15:14 tgt_lo, 17:16 succ_lo.
    localparam logic [17:0] P_STEP = 18'h1,   P_SFRW = 18'h2,   P_FUPD = 18'h4;
    localparam logic [17:0] P_FWR  = 18'h8,   P_SPW  = 18'h10;
    localparam logic [17:0] C_IND  = 18'h20,  C_SFRR = 18'h40,  C_FRD  = 18'h80;
    localparam logic [17:0] C_SPI  = 18'h100, C_CBR  = 18'h200;
    localparam logic [17:0] J_STD  = 18'h400, J_CACH = 18'h800;
    localparam logic [17:0] T_WIDE = 18'h1000, S_WIDE = 18'h2000;
    localparam logic [17:0] T_MIS  = 18'h8000, S_MIS  = 18'h20000;

    // Entry: {expected[2:0], producer word, consumer word}.
    localparam logic [38:0] VEC [NVEC] = '{
        {3'd1, P_STEP, C_IND},                                   // R2
        {3'd1, P_SFRW, C_SFRR},                                  // R3
        {3'd2, P_FUPD, C_FRD},                                   // R4
        {3'd2, P_SPW,  C_SPI},                                   // R5
        {3'd1, P_FWR,  C_CBR},                                   // R6
        {3'd2, 18'h0,  J_STD | T_WIDE | T_MIS},                  // R7
        {3'd0, 18'h0,  J_STD | T_WIDE},                          // R7 aligned
        {3'd0, 18'h0,  J_STD | T_MIS},                           // R7 narrow
        {3'd2, 18'h0,  J_CACH | T_WIDE | T_MIS | S_WIDE | S_MIS},// R8
        {3'd0, 18'h0,  J_CACH | T_WIDE | T_MIS | S_WIDE},        // R8 one aligned
        {3'd2, P_STEP | P_SFRW | P_FUPD, C_IND | C_SFRR | C_FRD},// R10
        {3'd1, P_STEP | P_SFRW, C_IND | C_SFRR},                 // R10
        {3'd0, C_SFRR, C_SFRR},                                  // R9
        {3'd0, P_STEP, C_SFRR}                                   // R9
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic issue_valid = 1'b0;
    logic [17:0] w = '0;
    logic [CNT_W-1:0] stall_cnt;
    logic stall_busy;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilk_stall_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .reg_step(w[0]), .sfr_wr(w[1]), .flag_upd(w[2]), .flag_wr(w[3]), .sp_wr(w[4]),
        .ind_ram_rd(w[5]), .sfr_rd(w[6]), .flag_rd(w[7]), .sp_implicit(w[8]),
        .cond_br(w[9]), .jump_std(w[10]), .jump_cached(w[11]), .tgt_wide(w[12]),
        .succ_wide(w[13]), .tgt_lo(w[15:14]), .succ_lo(w[17:16]),
        .stall_cnt(stall_cnt), .stall_busy(stall_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Issue one word at an idle moment; check the loaded count and window length.
    task automatic issue(input logic [17:0] word, input int exp, input string req);
        int n;
        while (stall_busy) @(negedge clk);
        w = word;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        w = '0;
        if (req != "") check(req, int'(stall_cnt), exp);
        n = 0;
        while (stall_busy) begin
            @(negedge clk);
            n++;
        end
        if (req != "") check({req, " busy window"}, n, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cnt", int'(stall_cnt), 0);
        check("R1 busy", int'(stall_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first instruction after reset sees cleared producer flags.
        issue(C_IND | C_SFRR | C_FRD | C_SPI | C_CBR, 0, "R1 first");

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][35:18], 0, "");
            issue(VEC[i][17:0], int'(VEC[i][38:36]), $sformatf("vec%0d", i));
        end

        // R9: an intervening instruction removes the hazard.
        issue(P_SFRW, 0, "");
        issue(18'h0, 0, "R9 nop");
        issue(C_SFRR, 0, "R9 separated");

        // R12: idle clocks do not separate, and their flags load nothing.
        issue(P_SFRW, 0, "");
        w = C_SFRR | C_FRD;
        repeat (3) @(negedge clk);
        check("R12 idle no load", int'(stall_cnt), 0);
        w = '0;
        issue(C_SFRR, 1, "R12 gap");

        // R11: issue while busy is ignored.
        issue(P_FUPD, 0, "");
        w = C_FRD;
        issue_valid = 1'b1;
        @(negedge clk);
        check("R11 load", int'(stall_cnt), 2);
        w = P_SPW | C_SFRR | J_STD | T_WIDE | T_MIS;
        @(negedge clk);
        check("R11 step1", int'(stall_cnt), 1);
        @(negedge clk);
        check("R11 step0", int'(stall_cnt), 0);
        issue_valid = 1'b0;
        w = '0;
        issue(C_SPI, 0, "R11 frozen flags");

        finish_run();
    end

endmodule